// File: doc/BRIEF.md
# Dual BCD Calendar Alarm Comparator

This block holds two independent alarm compare sets and watches the time and date supplied in BCD by an external timekeeper. Each set stores a second, minute, hour, date, month and day-of-week value, and each of those fields carries its own enable bit. On every one-second tick the block compares the enabled fields of each set against the current time. A set matches only when every enabled field is equal. A set with no enabled fields never matches.

When a set matches on a tick, a sticky flag for that alarm is raised in a status register. Software polls the flags and clears them by writing 0. An active-low interrupt line is driven from the flags through per-alarm enables. It runs in one of two modes: a level that holds until the flag is cleared, or a single-cycle pulse at the moment a flag is raised. Because each field is enabled on its own, one set can act as a daily, a weekly or a once-a-year alarm.

All registers are reached through a synchronous write port and a combinational read port, selected by address.

Top module: `cal_alarm_cmp`

## Requirements
- R1: After reset every alarm, control and status register reads 00h and irq_no is 1.
- R2: Alarm register map: alarm n field f is at address 8*n+f, with f = 0 second, 1 minute, 2 hour, 3 date, 4 month, 5 day of week. Addresses 8*n+6 and 8*n+7 read 0 and ignore writes. Control is at 10h and status at 11h. In every alarm register bit 7 is the enable. The stored value bits are [6:0] for second and minute, [5:0] for hour and date, [4:0] for month and [2:0] for day of week. All other bits read 0.
- R3: A set whose enabled fields all equal the current time fields raises its flag after the clock edge at which tick_i is 1.
- R4: Fields whose enable bit is 0 are not compared. With only hour and minute enabled, any second, date, month and day of week matches.
- R5: A set with all enable bits 0 never raises its flag, even when the stored values equal the current time.
- R6: A matching time while tick_i is 0 does not raise a flag.
- R7: A flag stays 1 across later ticks and time changes. Writing 0 to its status bit clears it, and writing 1 leaves it unchanged. If a set event and a clearing write occur in the same cycle, the set wins.
- R8: Alarm 0 owns status bit 5 and alarm 1 owns status bit 6. Each is raised only by its own set.
- R9: Control bit 7 is the pulse-mode select, bit 6 enables alarm 1 and bit 5 enables alarm 0. In level mode (bit 7 = 0), irq_no is 0 exactly while some flag with its enable bit set is 1.
- R10: In pulse mode (bit 7 = 1), irq_no is 0 for exactly one cycle, in the cycle after the edge where an enabled flag goes from 0 to 1. It then returns to 1 while the flag stays set.
- R11: The day-of-week field and the month and date fields take part in the comparison when enabled, which gives weekly and yearly alarms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-second compare strobe, one cycle wide |
| now_sec_i | input | 7 | Current seconds, BCD |
| now_min_i | input | 7 | Current minutes, BCD |
| now_hour_i | input | 6 | Current hour (0-23), BCD |
| now_date_i | input | 6 | Current day of month, BCD |
| now_month_i | input | 5 | Current month, BCD |
| now_dow_i | input | 3 | Current day of week, 0-6 |
| addr_i | input | 5 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| irq_no | output | 1 | Active-low interrupt |

## Verification
The assertions check on every cycle that a stored field holds exactly the masked write data, and that a flag rises only after a tick on which its set matched. They also check that a flag never drops without a clearing write, that a low interrupt in pulse mode coincides with a freshly raised flag, and that a low interrupt in level mode implies a set flag. Only the bench scenarios can show that partial-field patterns (daily, weekly, yearly) match or miss as intended. The same holds for an all-disabled set that stays silent, for the exact one-cycle pulse width, and for the gating of the interrupt by the per-alarm enables.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int unsigned NUM_ALARMS = 2;
  localparam int unsigned NUM_FIELDS = 6;
  localparam int unsigned FLD_W      = 7;
  localparam int unsigned FA_W       = 3;
  localparam int unsigned ADDR_W     = 5;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned FLAG_LSB   = 5;
  localparam int unsigned IM_BIT     = 7;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 5'h10;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 5'h11;

  typedef enum logic [FA_W-1:0] {
    F_SEC = 3'd0, F_MIN = 3'd1, F_HOUR = 3'd2,
    F_DATE = 3'd3, F_MONTH = 3'd4, F_DOW = 3'd5
  } field_e;

  // writable bits per field, bit 7 is the field enable
  function automatic logic [DATA_W-1:0] fld_mask(input int unsigned f);
    case (f)
      0, 1:    fld_mask = 8'hFF;
      2, 3:    fld_mask = 8'hBF;
      4:       fld_mask = 8'h9F;
      5:       fld_mask = 8'h87;
      default: fld_mask = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/alarm_set.sv
module alarm_set
  import cal_alarm_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  logic [FA_W-1:0]              waddr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  input  logic [FA_W-1:0]              raddr_i,
  output logic [DATA_W-1:0]            rdata_o,
  input  logic [NUM_FIELDS*FLD_W-1:0]  now_i,
  output logic                         match_o
);
  logic [DATA_W-1:0]     regs_q [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] en_v;
  logic [NUM_FIELDS-1:0] eq_v;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    localparam logic [DATA_W-1:0] MASK = fld_mask(f);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 regs_q[f] <= '0;
      else if (wr_i && waddr_i == FA_W'(f))        regs_q[f] <= wdata_i & MASK;
    end
    assign en_v[f] = regs_q[f][DATA_W-1];
    assign eq_v[f] = !en_v[f] || (regs_q[f][FLD_W-1:0] == now_i[f*FLD_W +: FLD_W]);

    AST_FIELD_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && waddr_i == FA_W'(f)) |=> (regs_q[f] == ($past(wdata_i) & MASK)))
      else $error("field write mismatch"); // R2
  end

  assign match_o = (|en_v) && (&eq_v);

  always_comb begin
    rdata_o = '0;
    for (int f = 0; f < NUM_FIELDS; f++)
      if (raddr_i == FA_W'(f)) rdata_o = regs_q[f];
  end
endmodule

// File: rtl/alarm_irq.sv
module alarm_irq
  import cal_alarm_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic [NUM_ALARMS-1:0] match_i,
  input  logic                  wr_ctrl_i,
  input  logic                  wr_stat_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     ctrl_o,
  output logic [DATA_W-1:0]     stat_o,
  output logic                  irq_no
);
  logic [NUM_ALARMS-1:0] flags_q, en_q, set_v, clr_v;
  logic                  im_q, pulse_q;

  for (genvar n = 0; n < NUM_ALARMS; n++) begin : g_flag
    assign set_v[n] = tick_i && match_i[n];
    assign clr_v[n] = wr_stat_i && !wdata_i[FLAG_LSB+n];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flags_q[n] <= 1'b0;
      else if (set_v[n]) flags_q[n] <= 1'b1;   // set wins over clear
      else if (clr_v[n]) flags_q[n] <= 1'b0;
    end

    AST_FLAG_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flags_q[n]) |-> $past(tick_i && match_i[n]))
      else $error("flag raised without matching tick"); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_q[n] && !(wr_stat_i && !wdata_i[FLAG_LSB+n])) |=> flags_q[n])
      else $error("flag dropped without clear"); // R7
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      im_q    <= 1'b0;
      en_q    <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (wr_ctrl_i) begin
        im_q <= wdata_i[IM_BIT];
        en_q <= wdata_i[FLAG_LSB +: NUM_ALARMS];
      end
      pulse_q <= |(set_v & ~flags_q & en_q);
    end
  end

  assign irq_no = !(im_q ? pulse_q : |(flags_q & en_q));

  always_comb begin
    ctrl_o = '0;
    stat_o = '0;
    ctrl_o[IM_BIT] = im_q;
    ctrl_o[FLAG_LSB +: NUM_ALARMS] = en_q;
    stat_o[FLAG_LSB +: NUM_ALARMS] = flags_q;
  end

  AST_PULSE_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (im_q && !irq_no) |-> (|(flags_q & ~$past(flags_q))))
    else $error("pulse without new flag"); // R10
  AST_LEVEL_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!im_q && !irq_no) |-> (|flags_q))
    else $error("level irq without flag"); // R9
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
  import cal_alarm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [6:0]        now_sec_i,
  input  logic [6:0]        now_min_i,
  input  logic [5:0]        now_hour_i,
  input  logic [5:0]        now_date_i,
  input  logic [4:0]        now_month_i,
  input  logic [2:0]        now_dow_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_no
);
  logic [NUM_FIELDS*FLD_W-1:0] now_flat;
  logic [NUM_ALARMS-1:0]       match_v;
  logic [DATA_W-1:0]           set_rdata [NUM_ALARMS];
  logic [DATA_W-1:0]           ctrl_rd, stat_rd;
  logic                        sel_alarm;

  assign now_flat = {4'b0, now_dow_i, 2'b0, now_month_i, 1'b0, now_date_i,
                     1'b0, now_hour_i, now_min_i, now_sec_i};
  assign sel_alarm = !addr_i[ADDR_W-1];

  for (genvar n = 0; n < NUM_ALARMS; n++) begin : g_set
    alarm_set u_set (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_en_i && sel_alarm && addr_i[FA_W] == 1'(n)),
      .waddr_i (addr_i[FA_W-1:0]),
      .wdata_i (wdata_i),
      .raddr_i (addr_i[FA_W-1:0]),
      .rdata_o (set_rdata[n]),
      .now_i   (now_flat),
      .match_o (match_v[n])
    );
  end

  alarm_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .match_i   (match_v),
    .wr_ctrl_i (wr_en_i && addr_i == CTRL_ADDR),
    .wr_stat_i (wr_en_i && addr_i == STAT_ADDR),
    .wdata_i   (wdata_i),
    .ctrl_o    (ctrl_rd),
    .stat_o    (stat_rd),
    .irq_no    (irq_no)
  );

  always_comb begin
    if (sel_alarm)                 rdata_o = set_rdata[addr_i[FA_W]];
    else if (addr_i == CTRL_ADDR)  rdata_o = ctrl_rd;
    else if (addr_i == STAT_ADDR)  rdata_o = stat_rd;
    else                           rdata_o = '0;
  end
endmodule

// File: tb/cal_alarm_cmp_test.sv
`timescale 1ns/1ps
module cal_alarm_cmp_test;
  logic       clk = 0, rst_n = 0, tick = 0, we = 0;
  logic [6:0] sec = 0, mn = 0;
  logic [5:0] hr = 0, dt = 0;
  logic [4:0] mo = 0;
  logic [2:0] dw = 0;
  logic [4:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic       irq_n;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cal_alarm_cmp uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .now_sec_i(sec), .now_min_i(mn), .now_hour_i(hr), .now_date_i(dt),
    .now_month_i(mo), .now_dow_i(dw), .addr_i(addr), .wr_en_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .irq_no(irq_n));

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd_chk(string req, logic [4:0] a, logic [7:0] exp);
    addr = a; #1;
    check(req, rdata, exp);
  endtask

  task automatic set_time(logic [6:0] s, logic [6:0] m, logic [5:0] h,
                          logic [5:0] d, logic [4:0] mth, logic [2:0] w);
    @(negedge clk); sec = s; mn = m; hr = h; dt = d; mo = mth; dw = w;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic t_reset();
    for (int a = 0; a < 16; a++) rd_chk("R1 alarm reg", 5'(a), 8'h00);
    rd_chk("R1 ctrl", 5'h10, 8'h00);
    rd_chk("R1 status", 5'h11, 8'h00);
    check("R1 irq idle", irq_n, 1);
  endtask

  task automatic t_regs();
    wr(5'h00, 8'hFF); rd_chk("R2 sec mask", 5'h00, 8'hFF);
    wr(5'h02, 8'hFF); rd_chk("R2 hour mask", 5'h02, 8'hBF);
    wr(5'h0B, 8'hFF); rd_chk("R2 date mask", 5'h0B, 8'hBF);
    wr(5'h04, 8'hFF); rd_chk("R2 month mask", 5'h04, 8'h9F);
    wr(5'h0D, 8'hFF); rd_chk("R2 dow mask", 5'h0D, 8'h87);
    wr(5'h06, 8'hFF); rd_chk("R2 unused addr", 5'h06, 8'h00);
    wr(5'h10, 8'hFF); rd_chk("R2 ctrl mask", 5'h10, 8'hE0);
    wr(5'h11, 8'hFF); rd_chk("R7 write one no effect", 5'h11, 8'h00);
    foreach (uut.g_set[0].u_set.regs_q[i]) ; // no-op
    for (int a = 0; a < 16; a++) wr(5'(a), 8'h00);
    wr(5'h10, 8'h00);
  endtask

  task automatic t_all_off();
    set_time(0, 0, 0, 0, 0, 0);
    pulse_tick();
    rd_chk("R5 all disabled never match", 5'h11, 8'h00);
  endtask

  task automatic t_daily();
    wr(5'h02, 8'h80 | 8'h21);
    wr(5'h01, 8'h80 | 8'h30);
    set_time(7'h45, 7'h30, 6'h21, 6'h17, 5'h04, 3'd2);
    repeat (3) @(negedge clk);
    rd_chk("R6 no tick no flag", 5'h11, 8'h00);
    pulse_tick();
    rd_chk("R3 R4 daily match", 5'h11, 8'h20);
    set_time(7'h10, 7'h31, 6'h05, 6'h01, 5'h09, 3'd6);
    pulse_tick(); pulse_tick();
    rd_chk("R7 sticky across ticks", 5'h11, 8'h20);
    wr(5'h11, 8'h20);
    rd_chk("R7 write one keeps flag", 5'h11, 8'h20);
    wr(5'h11, 8'h00);
    rd_chk("R7 write zero clears", 5'h11, 8'h00);
  endtask

  task automatic t_weekly_yearly();
    wr(5'h0D, 8'h80 | 8'h03);
    wr(5'h0A, 8'h80 | 8'h08);
    wr(5'h09, 8'h80 | 8'h00);
    set_time(7'h00, 7'h00, 6'h08, 6'h25, 5'h12, 3'd4);
    pulse_tick();
    rd_chk("R11 weekly wrong day", 5'h11, 8'h00);
    set_time(7'h00, 7'h00, 6'h08, 6'h25, 5'h12, 3'd3);
    pulse_tick();
    rd_chk("R8 R11 weekly alarm1 bit6", 5'h11, 8'h40);
    wr(5'h11, 8'h00);
    wr(5'h0C, 8'h80 | 8'h12);
    wr(5'h0B, 8'h80 | 8'h25);
    set_time(7'h00, 7'h00, 6'h08, 6'h25, 5'h11, 3'd3);
    pulse_tick();
    rd_chk("R11 yearly wrong month", 5'h11, 8'h00);
    set_time(7'h00, 7'h00, 6'h08, 6'h25, 5'h12, 3'd3);
    pulse_tick();
    rd_chk("R11 yearly match", 5'h11, 8'h40);
    wr(5'h11, 8'h00);
  endtask

  task automatic trig0();
    set_time(7'h05, 7'h30, 6'h21, 6'h02, 5'h03, 3'd1);
    pulse_tick();
  endtask

  task automatic t_irq_level();
    wr(5'h10, 8'h40);
    trig0();
    check("R9 masked alarm0 no irq", irq_n, 1);
    rd_chk("R8 alarm0 bit5 only", 5'h11, 8'h20);
    wr(5'h11, 8'h00);
    wr(5'h10, 8'h20);
    trig0();
    check("R9 level irq low", irq_n, 0);
    repeat (3) @(negedge clk);
    check("R9 level irq holds", irq_n, 0);
    wr(5'h11, 8'h00);
    check("R9 irq released on clear", irq_n, 1);
  endtask

  task automatic t_irq_pulse();
    wr(5'h10, 8'hE0);
    trig0();
    check("R10 pulse low", irq_n, 0);
    @(negedge clk);
    check("R10 pulse one cycle", irq_n, 1);
    rd_chk("R10 flag still set", 5'h11, 8'h20);
    pulse_tick();
    check("R10 no repeat pulse", irq_n, 1);
    // set and clear in the same cycle: set wins
    @(negedge clk); addr = 5'h11; wdata = 8'h00; we = 1; tick = 1;
    @(negedge clk); we = 0; tick = 0;
    rd_chk("R7 set beats clear", 5'h11, 8'h20);
    wr(5'h11, 8'h00);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_all_off();
    t_daily();
    t_weekly_yearly();
    t_irq_level();
    t_irq_pulse();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule